// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the configuration state of an addressable device into a set of decoded address windows. It watches a 16-bit command word, six general region registers and one expansion ROM register. Each region also carries its programmed size, which is a power of two or zero when the region is unused, and a space flag that marks it as I/O or memory. The ROM region is always memory. For each region the block reports a registered valid flag and a base address. It raises a one-cycle update strobe whenever that window's mapping changes.

A window is accepted only when the matching enable bit of the command word is set and the decoded range passes a set of sanity rules. Any window that fails a rule is treated as unmapped. A second, combinational path takes an incoming address together with its space flag. It reports whether a mapped window claims that address and gives the index of that window, so traffic can be steered to the owning region.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is asserted, every valid flag, every update strobe and the hit output are 0.
- R2: A region's base is its register value with the low log2(size) bits cleared, and its window ends at base + size - 1. The valid flag and base appear one clock after the inputs are sampled. An unmapped window reports base 0. Region index 0..5 are the general regions and index 6 is the ROM region; output bit or slice i belongs to region i.
- R3: An I/O region (region_io bit set) is mapped only while cmd_word bit 0 is 1. A memory region and the ROM region are mapped only while cmd_word bit 1 is 1.
- R4: A window whose base is zero is unmapped.
- R5: A window whose end address is at or below its base (address wrap, including size 1) is unmapped.
- R6: An I/O window whose end address is 0x10000 or above is unmapped. An end address of exactly 0xFFFF is accepted.
- R7: A memory or ROM window whose end address is all ones is unmapped.
- R8: The ROM window is mapped only while bit 0 of its register is 1. That bit is cleared in the reported base.
- R9: A region whose size is zero is never mapped and never strobes, whatever its register value.
- R10: win_update bit i is high for exactly the one cycle in which window i's valid flag or base takes a new value, and it stays low while neither changes.
- R11: hit is 1 when lookup_addr lies between a mapped window's base and end inclusive and lookup_io equals that window's space flag. The address one past the end and a lookup in the other space do not hit.
- R12: When several mapped windows claim the lookup address, hit_idx gives the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 16 | Command word; bit 0 enables I/O, bit 1 enables memory |
| region_reg | input | 7*32 | Region register values, slice i for region i |
| region_size | input | 7*32 | Region sizes (power of two, or 0 when unused) |
| region_io | input | 6 | Space flag of general regions, 1 = I/O |
| lookup_addr | input | 32 | Address to be matched against the windows |
| lookup_io | input | 1 | Space of the lookup address, 1 = I/O |
| win_valid | output | 7 | Window mapped flags |
| win_base | output | 7*32 | Window base addresses |
| win_update | output | 7 | One-cycle strobe on a window mapping change |
| hit | output | 1 | A mapped window claims the lookup address |
| hit_idx | output | 3 | Index of the claiming window |

## Verification
A lookup can fall in the same cycle as the update strobe of the window that claims it. The lookup reads the freshly registered windows, so the cycle that first maps a window must also report a hit on it. The bench holds a lookup address in place while it programs a region or toggles a command enable. It then expects the strobe, the new valid flag and the hit (or its loss) all in the one cycle after the change. The priority case is driven the same way: a second window is moved over an address that another window already claims, so the strobe and the lowest-index hit must both appear in that cycle.

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int NBAR = 6,
  parameter int AW = 32,
  parameter int unsigned IO_LIMIT = 32'h0001_0000,
  localparam int NREG = NBAR + 1,
  localparam int IW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cmd_word,
  input  logic [NREG*AW-1:0] region_reg,
  input  logic [NREG*AW-1:0] region_size,
  input  logic [NBAR-1:0]   region_io,
  input  logic [AW-1:0]     lookup_addr,
  input  logic              lookup_io,
  output logic [NREG-1:0]   win_valid,
  output logic [NREG*AW-1:0] win_base,
  output logic [NREG-1:0]   win_update,
  output logic              hit,
  output logic [IW-1:0]     hit_idx
);
  localparam logic [AW-1:0] IO_TOP = AW'(IO_LIMIT);

  logic [NREG-1:0] nxt_valid, nxt_io, io_q;
  logic [AW-1:0]   nxt_base [NREG];
  logic [AW-1:0]   nxt_last [NREG];
  logic [AW-1:0]   base_q   [NREG];
  logic [AW-1:0]   last_q   [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_win
    logic [AW-1:0] val, size, base, last;
    logic en, rom_ok, range_ok, ok;
    assign val  = region_reg[i*AW +: AW];
    assign size = region_size[i*AW +: AW];
    if (i == NBAR) begin : g_rom
      assign nxt_io[i] = 1'b0;
      assign rom_ok = val[0];
    end else begin : g_gen
      assign nxt_io[i] = region_io[i];
      assign rom_ok = 1'b1;
    end
    assign base = val & ~(size - 1'b1);
    assign last = base + size - 1'b1;
    assign en = nxt_io[i] ? cmd_word[0] : cmd_word[1];
    assign range_ok = nxt_io[i] ? (last < IO_TOP) : (last != '1);
    assign ok = (size != '0) && en && rom_ok && (base != '0) && (last > base) && range_ok;
    assign nxt_valid[i] = ok;
    assign nxt_base[i]  = ok ? base : '0;
    assign nxt_last[i]  = ok ? last : '0;
    assign win_base[i*AW +: AW] = base_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid  <= '0;
      win_update <= '0;
      io_q       <= '0;
      for (int k = 0; k < NREG; k++) begin
        base_q[k] <= '0;
        last_q[k] <= '0;
      end
    end else begin
      io_q <= nxt_io;
      win_valid <= nxt_valid;
      for (int k = 0; k < NREG; k++) begin
        win_update[k] <= (nxt_valid[k] != win_valid[k]) || (nxt_base[k] != base_q[k]);
        base_q[k] <= nxt_base[k];
        last_q[k] <= nxt_last[k];
      end
    end
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (win_valid[k] && (io_q[k] == lookup_io) &&
          (lookup_addr >= base_q[k]) && (lookup_addr <= last_q[k])) begin
        hit = 1'b1;
        hit_idx = IW'(k);
      end
    end
  end
endmodule

module win_decoder_chk #(
  parameter int NBAR = 6,
  parameter int AW = 32,
  localparam int NREG = NBAR + 1,
  localparam int IW = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cmd_word,
  input logic [NREG*AW-1:0] region_reg,
  input logic [NBAR-1:0]   region_io,
  input logic [NREG-1:0]   win_valid,
  input logic [NREG*AW-1:0] win_base,
  input logic [NREG-1:0]   win_update,
  input logic              hit,
  input logic [IW-1:0]     hit_idx
);
  for (genvar i = 0; i < NREG; i++) begin : g_chk
    // R10
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_update[i] |-> (win_valid[i] != $past(win_valid[i])) ||
                        (win_base[i*AW +: AW] != $past(win_base[i*AW +: AW])));
    // R10
    strobe_on_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid[i] != $past(win_valid[i])) |-> win_update[i]);
    // R4
    nonzero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid[i] |-> (win_base[i*AW +: AW] != '0));
    if (i < NBAR) begin : g_gen
      // R3
      io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_word[0] && region_io[i]) |=> !win_valid[i]);
      // R3
      mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_word[1] && !region_io[i]) |=> !win_valid[i]);
    end
  end
  // R8
  rom_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!region_reg[NBAR*AW] || !cmd_word[1]) |=> !win_valid[NBAR]);
  // R11
  hit_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> win_valid[hit_idx]);
endmodule

bind bar_window_decoder win_decoder_chk #(.NBAR(NBAR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .region_reg(region_reg),
  .region_io(region_io), .win_valid(win_valid), .win_base(win_base),
  .win_update(win_update), .hit(hit), .hit_idx(hit_idx));

// File: tb/tb_bar_window_decoder.sv
module tb_bar_window_decoder;
  localparam int NBAR = 6, AW = 32, NREG = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cmd_word = 16'h0003;
  logic [NREG*AW-1:0] region_reg = '0, region_size = '0;
  logic [NBAR-1:0] region_io = '0;
  logic [AW-1:0] lookup_addr = '0;
  logic lookup_io = 1'b0;
  logic [NREG-1:0] win_valid, win_update;
  logic [NREG*AW-1:0] win_base;
  logic hit;
  logic [2:0] hit_idx;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [6:0] v; logic [6:0] u; logic h; logic [2:0] x;
    int r; logic [31:0] b; string req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  bar_window_decoder dut (.*);

  task automatic setr(int i, logic [31:0] val, logic [31:0] size, logic io);
    region_reg[i*AW +: AW] = val;
    region_size[i*AW +: AW] = size;
    if (i < NBAR) region_io[i] = io;
  endtask

  task automatic look(logic [31:0] a, logic io);
    lookup_addr = a; lookup_io = io;
  endtask

  task automatic push(logic [6:0] v, logic [6:0] u, logic h, logic [2:0] x,
                      int r, logic [31:0] b, string req);
    exp_t e;
    e.v = v; e.u = u; e.h = h; e.x = x; e.r = r; e.b = b; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        logic [31:0] ab;
        bit bad;
        e = q.pop_front();
        ab = (e.r >= 0) ? win_base[e.r*AW +: AW] : 32'h0;
        bad = (win_valid !== e.v) || (win_update !== e.u) || (hit !== e.h) ||
              (e.h && hit_idx !== e.x) || (e.r >= 0 && ab !== e.b);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: valid=%h upd=%h hit=%b idx=%0d base=%h expected valid=%h upd=%h hit=%b idx=%0d base=%h",
                   e.req, win_valid, win_update, hit, hit_idx, ab, e.v, e.u, e.h, e.x, e.b);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (win_valid !== '0 || win_update !== '0 || hit !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid=%h upd=%h hit=%b expected 0 0 0", win_valid, win_update, hit);
    end
    rst_n = 1'b1;
    // R2 R10 R11: map I/O region 0, strobe and hit in the same cycle
    @(negedge clk); setr(0, 32'h0000_1234, 32'h100, 1'b1); look(32'h12FF, 1'b1);
    push(7'h01, 7'h01, 1, 0, 0, 32'h1200, "R2");
    // R11 one past end; R10 no strobe when unchanged
    @(negedge clk); look(32'h1300, 1'b1);
    push(7'h01, 7'h00, 0, 0, 0, 32'h1200, "R10");
    // R11 other space
    @(negedge clk); look(32'h1250, 1'b0);
    push(7'h01, 7'h00, 0, 0, -1, 0, "R11");
    // R3 I/O enable off
    @(negedge clk); cmd_word = 16'h0002;
    push(7'h00, 7'h01, 0, 0, 0, 32'h0, "R3");
    @(negedge clk); cmd_word = 16'h0003; look(32'h1200, 1'b1);
    push(7'h01, 7'h01, 1, 0, 0, 32'h1200, "R3");
    // R2 memory region 1
    @(negedge clk); setr(1, 32'h8000_0ABC, 32'h1000, 1'b0); look(32'h8000_0FFF, 1'b0);
    push(7'h03, 7'h02, 1, 1, 1, 32'h8000_0000, "R2");
    // R3 memory enable off
    @(negedge clk); cmd_word = 16'h0001;
    push(7'h01, 7'h02, 0, 0, 1, 32'h0, "R3");
    @(negedge clk); cmd_word = 16'h0003;
    push(7'h03, 7'h02, 1, 1, 1, 32'h8000_0000, "R3");
    // R4 zero base
    @(negedge clk); setr(2, 32'h0000_0050, 32'h100, 1'b0);
    push(7'h03, 7'h00, 1, 1, 2, 32'h0, "R4");
    // R5 size 1 wraps onto base
    @(negedge clk); setr(3, 32'h0000_4000, 32'h1, 1'b0);
    push(7'h03, 7'h00, 1, 1, 3, 32'h0, "R5");
    // R6 I/O ceiling
    @(negedge clk); setr(4, 32'h0001_0000, 32'h100, 1'b1);
    push(7'h03, 7'h00, 1, 1, 4, 32'h0, "R6");
    @(negedge clk); setr(4, 32'h0000_FF00, 32'h100, 1'b1);
    push(7'h13, 7'h10, 1, 1, 4, 32'h0000_FF00, "R6");
    // R7 memory end all ones
    @(negedge clk); setr(5, 32'hFFFF_F000, 32'h1000, 1'b0);
    push(7'h13, 7'h00, 1, 1, 5, 32'h0, "R7");
    @(negedge clk); setr(5, 32'hFFFF_E000, 32'h1000, 1'b0);
    push(7'h33, 7'h20, 1, 1, 5, 32'hFFFF_E000, "R7");
    // R8 ROM enable bit
    @(negedge clk); setr(6, 32'h000C_0000, 32'h800, 1'b0);
    push(7'h33, 7'h00, 1, 1, 6, 32'h0, "R8");
    @(negedge clk); setr(6, 32'h000C_0001, 32'h800, 1'b0); look(32'h000C_07FF, 1'b0);
    push(7'h73, 7'h40, 1, 6, 6, 32'h000C_0000, "R8");
    // R3 R8 ROM follows memory enable
    @(negedge clk); cmd_word = 16'h0001;
    push(7'h11, 7'h62, 0, 0, 6, 32'h0, "R8");
    @(negedge clk); cmd_word = 16'h0003;
    push(7'h73, 7'h62, 1, 6, 6, 32'h000C_0000, "R8");
    // R9 zero size ignored
    @(negedge clk); setr(2, 32'h1234_0000, 32'h0, 1'b0); look(32'h1234_0000, 1'b0);
    push(7'h73, 7'h00, 0, 0, 2, 32'h0, "R9");
    // R12 overlap, lowest index wins
    @(negedge clk); setr(5, 32'h8000_0000, 32'h2000, 1'b0); look(32'h8000_0800, 1'b0);
    push(7'h73, 7'h20, 1, 1, 5, 32'h8000_0000, "R12");
    @(negedge clk); look(32'h8000_1800, 1'b0);
    push(7'h73, 7'h00, 1, 5, 5, 32'h8000_0000, "R12");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule